// File: doc/BRIEF.md
# Stack Call/Return/Break Bus Sequencer

This block generates the cycle-by-cycle bus activity of the four stack-using control-transfer instructions of an 8-bit processor: software break, subroutine call, subroutine return and interrupt return. On a start strobe it captures the instruction class, the program counter and the 8-bit stack pointer. It then issues exactly one bus access per cycle, either a read or a write, with its address, following a fixed script for that instruction. The script includes the dummy reads the processor performs.

Stack accesses are confined to a single 256-byte page. Stack-pointer offsets wrap modulo 256, so an access never leaves that page. The data bytes written to the stack come from an external data path and are not handled here. The block reads back only the two return-address bytes, because a subroutine return ends with a dummy read at the address it has just popped. When the script is complete, the block pulses `done` and presents the updated stack pointer.

Top module: `stackSequencer`

## Requirements
- R1: After reset, `busRd`, `busWr` and `done` are 0 and `spOut` is 0.
- R2: For `opSel`=0 (software break) the 7 accesses are: read PC, read PC+1, write S, write S-1, write S-2, read 0xFFFE, read 0xFFFF. The final stack pointer is S-3.
- R3: For `opSel`=1 (subroutine call) the 6 accesses are: read PC, read PC+1, read S, write S, write S-1, read PC+2. The final stack pointer is S-2.
- R4: For `opSel`=2 (subroutine return) the 6 accesses are: read PC, read PC+1, read S, read S+1, read S+2, and a final read at the address {byte read at S+2, byte read at S+1}. The final stack pointer is S+2.
- R5: For `opSel`=3 (interrupt return) the 6 accesses are: read PC, read PC+1, read S, read S+1, read S+2, read S+3. The final stack pointer is S+3.
- R6: A stack access at offset S+k drives address {0x01, (S+k) mod 256}. All writes fall in page 0x01, and the final stack pointer also wraps modulo 256.
- R7: Each active cycle carries exactly one of `busRd` or `busWr`. When no instruction is in progress, neither is asserted.
- R8: `done` is a one-cycle pulse in the cycle after the last access. `spOut` takes its new value in that same cycle and holds it otherwise.
- R9: A `start` raised while an instruction is in progress is ignored, and the running script continues unchanged.
- R10: When `start` is sampled high while idle, the first access (read PC) appears in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction script (sampled when idle) |
| opSel | input | 2 | Instruction class: 0 break, 1 call, 2 return, 3 interrupt return |
| pcIn | input | 16 | Address of the opcode byte |
| spIn | input | 8 | Stack pointer at instruction start |
| busDataIn | input | 8 | Read data, used to capture the popped return address |
| busAddr | output | 16 | Address of the current access |
| busRd | output | 1 | Current access is a read |
| busWr | output | 1 | Current access is a write |
| spOut | output | 8 | Updated stack pointer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench starts each instruction with stack pointers near 0x00 and 0xFF. A design that carried into the page byte, or let offsets escape page 0x01, would put writes or pops at wrong addresses and return a stack pointer that is off by 256. The subroutine return is run with a data pattern that makes the popped address distinct from every other address, which catches swapped byte order or a missing final dummy read. A second start is injected mid-script; a design that restarted or switched instruction would break the expected access order. A program counter of 0xFFFF checks that PC+2 wraps in 16 bits.

// File: rtl/stackSeqPkg.sv
package stackSeqPkg;

  typedef enum logic [1:0] {
    OP_BREAK = 2'd0,
    OP_CALL  = 2'd1,
    OP_RET   = 2'd2,
    OP_IRET  = 2'd3
  } seqOp_e;

  typedef enum logic [3:0] {
    SEL_PC0, SEL_PC1, SEL_PC2,
    SEL_SP0, SEL_SPM1, SEL_SPM2,
    SEL_SPP1, SEL_SPP2, SEL_SPP3,
    SEL_VECLO, SEL_VECHI, SEL_RET
  } addrSel_e;

  typedef struct packed {
    logic     load;
    logic     access;
    logic     isWrite;
    addrSel_e sel;
    logic     capLo;
    logic     capHi;
    logic     finish;
  } seqStrobe_t;

  localparam int BREAK_LEN = 7;
  localparam int OTHER_LEN = 6;

endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import stackSeqPkg::*;
#(
  parameter int MAX_LEN = BREAK_LEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  seqOp_e     opIn,
  output seqStrobe_t strb,
  output logic       done
);

  localparam int STEP_W = $clog2(MAX_LEN);

  logic              busy;
  logic [STEP_W-1:0] step;
  seqOp_e            opReg;
  logic              lastStep;

  always_comb begin
    if (opReg == OP_BREAK) lastStep = (step == STEP_W'(BREAK_LEN - 1));
    else                   lastStep = (step == STEP_W'(OTHER_LEN - 1));
  end

  always_comb begin
    strb         = '0;
    strb.sel     = SEL_PC0;
    strb.load    = start && !busy;
    if (busy) begin
      strb.access = 1'b1;
      strb.finish = lastStep;
      case (step)
        STEP_W'(0): strb.sel = SEL_PC0;
        STEP_W'(1): strb.sel = SEL_PC1;
        default: begin
          case (opReg)
            OP_BREAK: begin
              case (step)
                STEP_W'(2): begin strb.sel = SEL_SP0;  strb.isWrite = 1'b1; end
                STEP_W'(3): begin strb.sel = SEL_SPM1; strb.isWrite = 1'b1; end
                STEP_W'(4): begin strb.sel = SEL_SPM2; strb.isWrite = 1'b1; end
                STEP_W'(5): strb.sel = SEL_VECLO;
                default:    strb.sel = SEL_VECHI;
              endcase
            end
            OP_CALL: begin
              case (step)
                STEP_W'(2): strb.sel = SEL_SP0;
                STEP_W'(3): begin strb.sel = SEL_SP0;  strb.isWrite = 1'b1; end
                STEP_W'(4): begin strb.sel = SEL_SPM1; strb.isWrite = 1'b1; end
                default:    strb.sel = SEL_PC2;
              endcase
            end
            OP_RET: begin
              case (step)
                STEP_W'(2): strb.sel = SEL_SP0;
                STEP_W'(3): begin strb.sel = SEL_SPP1; strb.capLo = 1'b1; end
                STEP_W'(4): begin strb.sel = SEL_SPP2; strb.capHi = 1'b1; end
                default:    strb.sel = SEL_RET;
              endcase
            end
            default: begin
              case (step)
                STEP_W'(2): strb.sel = SEL_SP0;
                STEP_W'(3): strb.sel = SEL_SPP1;
                STEP_W'(4): strb.sel = SEL_SPP2;
                default:    strb.sel = SEL_SPP3;
              endcase
            end
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      step  <= '0;
      opReg <= OP_BREAK;
      done  <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.load) begin
        busy  <= 1'b1;
        step  <= '0;
        opReg <= opIn;
      end else if (busy) begin
        if (lastStep) begin
          busy <= 1'b0;
          step <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import stackSeqPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SP_W       = 8,
  parameter int STACK_PAGE = 1,
  parameter int VEC_ADDR   = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strb,
  input  seqOp_e            opIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [SP_W-1:0]   spIn,
  input  logic [SP_W-1:0]   busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [SP_W-1:0]   spOut
);

  localparam int PAGE_W = ADDR_W - SP_W;
  localparam logic [PAGE_W-1:0] PAGE = PAGE_W'(STACK_PAGE);

  logic [ADDR_W-1:0] pcReg;
  logic [SP_W-1:0]   spReg;
  logic [SP_W-1:0]   retLo;
  logic [SP_W-1:0]   retHi;
  seqOp_e            opReg;
  logic [SP_W-1:0]   spFinal;

  function automatic logic [ADDR_W-1:0] stackAddr(input logic [SP_W-1:0] ofs);
    return {PAGE, ofs};
  endfunction

  always_comb begin
    case (strb.sel)
      SEL_PC0:   busAddr = pcReg;
      SEL_PC1:   busAddr = pcReg + ADDR_W'(1);
      SEL_PC2:   busAddr = pcReg + ADDR_W'(2);
      SEL_SP0:   busAddr = stackAddr(spReg);
      SEL_SPM1:  busAddr = stackAddr(spReg - SP_W'(1));
      SEL_SPM2:  busAddr = stackAddr(spReg - SP_W'(2));
      SEL_SPP1:  busAddr = stackAddr(spReg + SP_W'(1));
      SEL_SPP2:  busAddr = stackAddr(spReg + SP_W'(2));
      SEL_SPP3:  busAddr = stackAddr(spReg + SP_W'(3));
      SEL_VECLO: busAddr = ADDR_W'(VEC_ADDR);
      SEL_VECHI: busAddr = ADDR_W'(VEC_ADDR + 1);
      SEL_RET:   busAddr = {retHi[ADDR_W-SP_W-1:0], retLo};
      default:   busAddr = pcReg;
    endcase
  end

  assign busRd = strb.access && !strb.isWrite;
  assign busWr = strb.access && strb.isWrite;

  always_comb begin
    case (opReg)
      OP_BREAK: spFinal = spReg - SP_W'(3);
      OP_CALL:  spFinal = spReg - SP_W'(2);
      OP_RET:   spFinal = spReg + SP_W'(2);
      default:  spFinal = spReg + SP_W'(3);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcReg <= '0;
      spReg <= '0;
      retLo <= '0;
      retHi <= '0;
      opReg <= OP_BREAK;
      spOut <= '0;
    end else begin
      if (strb.load) begin
        pcReg <= pcIn;
        spReg <= spIn;
        opReg <= opIn;
      end
      if (strb.capLo)  retLo <= busDataIn;
      if (strb.capHi)  retHi <= busDataIn;
      if (strb.finish) spOut <= spFinal;
    end
  end

endmodule

// File: rtl/stackSequencer.sv
module stackSequencer
  import stackSeqPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SP_W       = 8,
  parameter int STACK_PAGE = 1,
  parameter int VEC_ADDR   = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        opSel,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [SP_W-1:0]   spIn,
  input  logic [SP_W-1:0]   busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [SP_W-1:0]   spOut,
  output logic              done
);

  seqStrobe_t strb;
  seqOp_e     opIn;

  assign opIn = seqOp_e'(opSel);

  seqCtrl #(.MAX_LEN(BREAK_LEN)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .opIn  (opIn),
    .strb  (strb),
    .done  (done)
  );

  seqDatapath #(
    .ADDR_W     (ADDR_W),
    .SP_W       (SP_W),
    .STACK_PAGE (STACK_PAGE),
    .VEC_ADDR   (VEC_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .opIn      (opIn),
    .pcIn      (pcIn),
    .spIn      (spIn),
    .busDataIn (busDataIn),
    .busAddr   (busAddr),
    .busRd     (busRd),
    .busWr     (busWr),
    .spOut     (spOut)
  );

endmodule

// File: rtl/stackSequencerChk.sv
module stackSequencerChk #(
  parameter int ADDR_W     = 16,
  parameter int SP_W       = 8,
  parameter int STACK_PAGE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] pcIn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [SP_W-1:0]   spOut,
  input logic              done
);

  localparam int PAGE_W = ADDR_W - SP_W;

  assert_one_direction_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busRd && busWr));

  assert_quiet_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busRd && !busWr));

  assert_write_in_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busWr |-> (busAddr[ADDR_W-1:SP_W] == PAGE_W'(STACK_PAGE)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_sp_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(spOut));

  assert_first_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busRd && !busWr) |=> (busRd && busAddr == $past(pcIn)));

endmodule

bind stackSequencer stackSequencerChk #(
  .ADDR_W     (ADDR_W),
  .SP_W       (SP_W),
  .STACK_PAGE (STACK_PAGE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .pcIn    (pcIn),
  .busAddr (busAddr),
  .busRd   (busRd),
  .busWr   (busWr),
  .spOut   (spOut),
  .done    (done)
);

// File: tb/sim_stackSequencer.sv
`timescale 1ns/1ps
module sim_stackSequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic [15:0] pcIn = 16'h0000;
  logic [7:0]  spIn = 8'h00;
  logic [7:0]  busDataIn;
  logic [15:0] busAddr;
  logic        busRd;
  logic        busWr;
  logic [7:0]  spOut;
  logic        done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  assign busDataIn = memByte(busAddr);

  stackSequencer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .opSel     (opSel),
    .pcIn      (pcIn),
    .spIn      (spIn),
    .busDataIn (busDataIn),
    .busAddr   (busAddr),
    .busRd     (busRd),
    .busWr     (busWr),
    .spOut     (spOut),
    .done      (done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stk(input logic [7:0] ofs);
    return {8'h01, ofs};
  endfunction

  // {isWrite, addr} of access k
  function automatic logic [16:0] expAccess(input int op, input int k,
                                            input logic [15:0] pc, input logic [7:0] sp);
    logic [15:0] ret;
    ret = {memByte(stk(sp + 8'd2)), memByte(stk(sp + 8'd1))};
    if (k == 0) return {1'b0, pc};
    if (k == 1) return {1'b0, pc + 16'd1};
    case (op)
      0: case (k)
           2: return {1'b1, stk(sp)};
           3: return {1'b1, stk(sp - 8'd1)};
           4: return {1'b1, stk(sp - 8'd2)};
           5: return {1'b0, 16'hFFFE};
           default: return {1'b0, 16'hFFFF};
         endcase
      1: case (k)
           2: return {1'b0, stk(sp)};
           3: return {1'b1, stk(sp)};
           4: return {1'b1, stk(sp - 8'd1)};
           default: return {1'b0, pc + 16'd2};
         endcase
      2: case (k)
           2: return {1'b0, stk(sp)};
           3: return {1'b0, stk(sp + 8'd1)};
           4: return {1'b0, stk(sp + 8'd2)};
           default: return {1'b0, ret};
         endcase
      default: case (k)
           2: return {1'b0, stk(sp)};
           3: return {1'b0, stk(sp + 8'd1)};
           4: return {1'b0, stk(sp + 8'd2)};
           default: return {1'b0, stk(sp + 8'd3)};
         endcase
    endcase
  endfunction

  function automatic logic [7:0] expSp(input int op, input logic [7:0] sp);
    case (op)
      0: return sp - 8'd3;
      1: return sp - 8'd2;
      2: return sp + 8'd2;
      default: return sp + 8'd3;
    endcase
  endfunction

  // Runs one script; req names the script requirement, intrude pulses start mid-script.
  task automatic runOp(input string req, input int op, input logic [15:0] pc,
                       input logic [7:0] sp, input bit intrude);
    int len;
    logic [16:0] e;
    len = (op == 0) ? 7 : 6;
    @(negedge clk);
    start = 1'b1; opSel = 2'(op); pcIn = pc; spIn = sp;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; pcIn = 16'h5555; spIn = 8'h77;
    for (int k = 0; k < len; k++) begin
      e = expAccess(op, k, pc, sp);
      check({req, " addr"}, {16'h0, busAddr}, {16'h0, e[15:0]});
      check({req, " R7 dir"}, {30'h0, busRd, busWr}, {30'h0, !e[16], e[16]});
      check({req, " R8 no done"}, {31'h0, done}, 32'h0);
      if (k == 0) check("R10 first fetch", {31'h0, busRd}, 32'h1);
      if (intrude && k == 2) begin
        start = 1'b1; opSel = 2'(op ^ 1); pcIn = 16'h1234; spIn = 8'h40;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check("R8 done pulse", {31'h0, done}, 32'h1);
    check({req, " sp"}, {24'h0, spOut}, {24'h0, expSp(op, sp)});
    check("R7 idle at done", {30'h0, busRd, busWr}, 32'h0);
    @(negedge clk);
    check("R8 done drops", {31'h0, done}, 32'h0);
    check("R8 sp holds", {24'h0, spOut}, {24'h0, expSp(op, sp)});
    check("R7 idle after", {30'h0, busRd, busWr}, 32'h0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd/wr", {30'h0, busRd, busWr}, 32'h0);
    check("R1 done", {31'h0, done}, 32'h0);
    check("R1 sp", {24'h0, spOut}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle", {30'h0, busRd, busWr}, 32'h0);

    runOp("R2", 0, 16'h0300, 8'hFD, 1'b0);
    runOp("R3", 1, 16'h0410, 8'hF0, 1'b0);
    runOp("R4", 2, 16'h0520, 8'hF0, 1'b0);
    runOp("R5", 3, 16'h0630, 8'hE0, 1'b0);
    // R6 page wrap corners
    runOp("R6 R2 wrap", 0, 16'h8000, 8'h01, 1'b0);
    runOp("R6 R3 wrap", 1, 16'hFFFF, 8'h00, 1'b0);
    runOp("R6 R4 wrap", 2, 16'h1000, 8'hFE, 1'b0);
    runOp("R6 R5 wrap", 3, 16'h2000, 8'hFF, 1'b0);
    // R9 start while busy
    runOp("R9 R4", 2, 16'h0700, 8'h80, 1'b1);
    runOp("R9 R2", 0, 16'h0800, 8'h10, 1'b1);
    finishRun();
  end

endmodule